// File: doc/BRIEF.md
# Entropy-Preserving Merge and Random-Math ALU

This block is a 32-bit datapath with two functions. The caller presents two operands, a selector word and a mode bit, together with a one-cycle valid pulse. In math mode, the remainder of the selector modulo 11 picks one of eleven operations applied to the two operands. In merge mode, the remainder of the selector modulo 4 picks one of four ways to fold the second operand into the first. Every merge operation leaves the first operand's entropy intact, even when the second operand carries little information.

The result sits in a register and comes out one clock after the valid pulse, with an output valid bit beside it. Between pulses the output register keeps its last value. Picking which registers feed the unit, fetching memory data and generating the selector words are the caller's job.

Top module: `entropy_mix_alu`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_result is 0 until the first accepted operation.
- R2: out_valid is 1 exactly in the cycle after a cycle in which in_valid was 1, and 0 otherwise.
- R3: With in_merge=1 and in_sel mod 4 = 0, the result is in_a*33 + in_b modulo 2^32.
- R4: With in_merge=1 and in_sel mod 4 = 1, the result is (in_a XOR in_b)*33 modulo 2^32.
- R5: With in_merge=1 and in_sel mod 4 = 2 (or 3), the result is in_a rotated left (or right) by bits 20..16 of in_sel, then XORed with in_b. A rotation of 0 gives in_a XOR in_b.
- R6: With in_merge=0, in_sel mod 11 values 0, 1 and 2 give in_a+in_b, the low 32 bits of in_a*in_b, and the high 32 bits of the unsigned 64-bit product.
- R7: With in_merge=0 and in_sel mod 11 = 3, the result is the unsigned minimum of in_a and in_b.
- R8: With in_merge=0, in_sel mod 11 values 4 and 5 rotate in_a left and right by in_b mod 32. A rotation of 0 returns in_a.
- R9: With in_merge=0, in_sel mod 11 values 6, 7 and 8 give bitwise AND, OR and XOR.
- R10: With in_merge=0 and in_sel mod 11 = 9, the result is the sum of the leading-zero counts of in_a and in_b. A zero operand counts 32, so the sum ranges from 0 to 64.
- R11: With in_merge=0 and in_sel mod 11 = 10, the result is the sum of the population counts of in_a and in_b.
- R12: In a cycle after in_valid was 0, out_result keeps its previous value, whatever the operand, selector and mode inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request, one cycle per operation |
| in_merge | input | 1 | 1 selects the merge function, 0 selects the math function |
| in_a | input | 32 | First operand, or the accumulator in merge mode |
| in_b | input | 32 | Second operand, or the value folded in during merge mode |
| in_sel | input | 32 | Selector word that picks the operation |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after the cycle in which its request was driven. No result arrives sooner or later, and a cycle without a request leaves the output register as it was. The bench drives inputs on the falling edge and compares both outputs on the next falling edge, on every clock, against a behavioural model that keeps one pending expected value. A mismatch therefore cannot hide behind a result that shows up early or late. Directed cases cover rotations by 0, 31 and 32 or more, zero operands for the counts, equal operands for the minimum, and full-scale products. A long pseudo-random stretch follows, with gaps between requests.

// File: rtl/ema_pkg.sv
package ema_pkg;

  localparam int MATH_OP_COUNT  = 11;
  localparam int MERGE_OP_COUNT = 4;

  typedef enum logic [3:0] {
    MOP_ADD    = 4'd0,
    MOP_MULLO  = 4'd1,
    MOP_MULHI  = 4'd2,
    MOP_MIN    = 4'd3,
    MOP_ROTL   = 4'd4,
    MOP_ROTR   = 4'd5,
    MOP_AND    = 4'd6,
    MOP_OR     = 4'd7,
    MOP_XOR    = 4'd8,
    MOP_LZSUM  = 4'd9,
    MOP_POPSUM = 4'd10
  } math_op_e;

  typedef enum logic [1:0] {
    GOP_MULADD = 2'd0,
    GOP_XORMUL = 2'd1,
    GOP_ROLXOR = 2'd2,
    GOP_RORXOR = 2'd3
  } merge_op_e;

endpackage

// File: rtl/ema_bitcount.sv
module ema_bitcount #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] lead_zeros,
  output logic [CW-1:0] ones
);

  // seen_one[i] is 1 when any bit at position i or above is set
  logic [W-1:0] seen_one;

  assign seen_one[W-1] = val[W-1];
  genvar g;
  generate
    for (g = 0; g < W - 1; g++) begin : g_prefix
      assign seen_one[g] = seen_one[g+1] | val[g];
    end
  endgenerate

  function automatic logic [CW-1:0] count_set(input logic [W-1:0] x);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) n = n + CW'(x[i]);
    return n;
  endfunction

  assign ones       = count_set(val);
  assign lead_zeros = count_set(~seen_one);

  always_comb begin
    if (val == '0) begin
      // R10
      lz_of_zero_chk: assert (lead_zeros == CW'(W));
      // R11
      pop_of_zero_chk: assert (ones == '0);
    end
  end

endmodule

// File: rtl/ema_math_unit.sv
module ema_math_unit
  import ema_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W),
  localparam int CW  = $clog2(W + 1)
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] sel,
  output math_op_e     op,
  output logic [W-1:0] res
);

  logic [W-1:0]   sel_rem;
  logic [2*W-1:0] product;
  logic [CW-1:0]  lz_a, lz_b, pop_a, pop_b;
  logic [SHW-1:0] amt;

  assign sel_rem = sel % W'(MATH_OP_COUNT);
  assign op      = math_op_e'(sel_rem[3:0]);
  assign product = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};
  assign amt     = opb[SHW-1:0];

  ema_bitcount #(.W(W)) u_cnt_a (.val(opa), .lead_zeros(lz_a), .ones(pop_a));
  ema_bitcount #(.W(W)) u_cnt_b (.val(opb), .lead_zeros(lz_b), .ones(pop_b));

  function automatic logic [W-1:0] rot_left(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic [2*W-1:0] twice;
    twice = {x, x} << s;
    return twice[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] rot_right(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic [2*W-1:0] twice;
    twice = {x, x} >> s;
    return twice[W-1:0];
  endfunction

  function automatic logic [W-1:0] umin(input logic [W-1:0] x, input logic [W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  always_comb begin
    unique case (op)
      MOP_ADD:    res = opa + opb;
      MOP_MULLO:  res = product[W-1:0];
      MOP_MULHI:  res = product[2*W-1:W];
      MOP_MIN:    res = umin(opa, opb);
      MOP_ROTL:   res = rot_left(opa, amt);
      MOP_ROTR:   res = rot_right(opa, amt);
      MOP_AND:    res = opa & opb;
      MOP_OR:     res = opa | opb;
      MOP_XOR:    res = opa ^ opb;
      MOP_LZSUM:  res = W'(lz_a) + W'(lz_b);
      MOP_POPSUM: res = W'(pop_a) + W'(pop_b);
      default:    res = '0;
    endcase
  end

  always_comb begin
    if (op == MOP_MIN) begin
      // R7
      min_bound_chk: assert (res <= opa && res <= opb);
    end
    if ((op == MOP_ROTL || op == MOP_ROTR) && amt == '0) begin
      // R8
      rot_zero_math_chk: assert (res == opa);
    end
  end

endmodule

// File: rtl/ema_merge_unit.sv
module ema_merge_unit
  import ema_pkg::*;
#(
  parameter int W = 32,
  parameter int ROT_FIELD_LSB = 16,
  parameter int SCALE_SHIFT = 5,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] val,
  input  logic [W-1:0] sel,
  output merge_op_e    op,
  output logic [W-1:0] res
);

  logic [SHW-1:0] amt;

  assign op  = merge_op_e'(sel[1:0]);
  assign amt = sel[ROT_FIELD_LSB +: SHW];

  // multiply by (2^SCALE_SHIFT + 1) through shift-add
  function automatic logic [W-1:0] scale33(input logic [W-1:0] x);
    return (x << SCALE_SHIFT) + x;
  endfunction

  function automatic logic [W-1:0] rot_left(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic [2*W-1:0] twice;
    twice = {x, x} << s;
    return twice[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] rot_right(input logic [W-1:0] x, input logic [SHW-1:0] s);
    logic [2*W-1:0] twice;
    twice = {x, x} >> s;
    return twice[W-1:0];
  endfunction

  always_comb begin
    unique case (op)
      GOP_MULADD: res = scale33(acc) + val;
      GOP_XORMUL: res = scale33(acc ^ val);
      GOP_ROLXOR: res = rot_left(acc, amt) ^ val;
      GOP_RORXOR: res = rot_right(acc, amt) ^ val;
      default:    res = '0;
    endcase
  end

  always_comb begin
    if ((op == GOP_ROLXOR || op == GOP_RORXOR) && amt == '0) begin
      // R5
      rot_zero_merge_chk: assert (res == (acc ^ val));
    end
  end

endmodule

// File: rtl/entropy_mix_alu.sv
module entropy_mix_alu
  import ema_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_merge,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);

  math_op_e          math_op;
  merge_op_e         merge_op;
  logic [DATA_W-1:0] math_res;
  logic [DATA_W-1:0] merge_res;
  logic [DATA_W-1:0] next_result;
  logic              capture_en;

  ema_math_unit #(.W(DATA_W)) u_math (
    .opa(in_a), .opb(in_b), .sel(in_sel), .op(math_op), .res(math_res)
  );

  ema_merge_unit #(.W(DATA_W)) u_merge (
    .acc(in_a), .val(in_b), .sel(in_sel), .op(merge_op), .res(merge_res)
  );

  assign capture_en  = in_valid;
  assign next_result = in_merge ? merge_res : math_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= capture_en;
      if (capture_en) out_result <= next_result;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  // R3
  merge_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_merge && merge_op == GOP_MULADD && in_b == '0)
      |=> out_result == $past(in_a) * DATA_W'(33));

endmodule

// File: tb/entropy_mix_alu_tb.sv
module entropy_mix_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_merge = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [31:0] in_sel = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // pending expectation for the next falling edge
  bit          exp_v = 1'b0;
  logic [31:0] exp_r = '0;
  string       exp_tag = "R1";

  always #2 clk = ~clk;

  entropy_mix_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_merge(in_merge),
    .in_a(in_a), .in_b(in_b), .in_sel(in_sel),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic int lz_of(input logic [31:0] x);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (x[i]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int pop_of(input logic [31:0] x);
    int n = 0;
    for (int i = 0; i < 32; i++) if (x[i]) n++;
    return n;
  endfunction

  function automatic logic [31:0] spin_l(input logic [31:0] x, input int k);
    logic [31:0] y = x;
    for (int i = 0; i < k; i++) y = {y[30:0], y[31]};
    return y;
  endfunction

  function automatic logic [31:0] spin_r(input logic [31:0] x, input int k);
    logic [31:0] y = x;
    for (int i = 0; i < k; i++) y = {y[0], y[31:1]};
    return y;
  endfunction

  function automatic logic [31:0] model(input bit mg, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] s);
    longint unsigned p;
    longint unsigned ua = 64'(a);
    longint unsigned ub = 64'(b);
    if (mg) begin
      case (s % 4)
        0: p = ua * 33 + ub;
        1: p = (64'(a ^ b)) * 33;
        2: p = 64'(spin_l(a, int'((s >> 16) % 32)) ^ b);
        default: p = 64'(spin_r(a, int'((s >> 16) % 32)) ^ b);
      endcase
      return p[31:0];
    end
    p = ua * ub;
    case (s % 11)
      0: return a + b;
      1: return p[31:0];
      2: return p[63:32];
      3: return (ua <= ub) ? a : b;
      4: return spin_l(a, int'(b % 32));
      5: return spin_r(a, int'(b % 32));
      6: return a & b;
      7: return a | b;
      8: return a ^ b;
      9: return 32'(lz_of(a) + lz_of(b));
      default: return 32'(pop_of(a) + pop_of(b));
    endcase
  endfunction

  function automatic string tag_of(input bit mg, input logic [31:0] s);
    if (mg) begin
      case (s % 4)
        0: return "R3";
        1: return "R4";
        default: return "R5";
      endcase
    end
    case (s % 11)
      0, 1, 2: return "R6";
      3: return "R7";
      4, 5: return "R8";
      6, 7, 8: return "R9";
      9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_now();
    checks++;
    if (out_valid !== exp_v) begin
      failures++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, exp_v);
    end
    checks++;
    if (out_result !== exp_r) begin
      failures++;
      $display("FAIL %s out_result actual=%h expected=%h", exp_tag, out_result, exp_r);
    end
  endtask

  // one clock: check the outputs of the previous request, then drive the next
  task automatic cyc(input bit v, input bit mg, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] s);
    @(negedge clk);
    compare_now();
    in_valid = v; in_merge = mg; in_a = a; in_b = b; in_sel = s;
    exp_v = v;
    if (v) begin
      exp_r = model(mg, a, b, s);
      exp_tag = tag_of(mg, s);
    end else begin
      exp_tag = "R12";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: outputs are clear during reset, driven inputs notwithstanding
    in_valid = 1'b1; in_a = 32'hFFFF_FFFF; in_b = 32'h1234_5678;
    repeat (3) begin
      @(negedge clk);
      compare_now();
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_tag = "R1";
    cyc(0, 0, 32'hDEAD_BEEF, 32'h1, 32'h0);
    cyc(0, 1, 32'hDEAD_BEEF, 32'h1, 32'h0);

    // R3 / R4: merge scale paths, with wraparound
    cyc(1, 1, 32'h0000_0003, 32'h0000_0005, 32'h0000_0000);
    cyc(1, 1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0004);
    cyc(1, 1, 32'h1357_9BDF, 32'h2468_ACE0, 32'h0000_0001);
    cyc(1, 1, 32'h8000_0001, 32'h8000_0000, 32'hFFFF_FFFD);
    // R5: rotation field in bits 20..16, zero rotation and 31
    cyc(1, 1, 32'h8000_0001, 32'h0000_00F0, 32'h0000_0002);
    cyc(1, 1, 32'h8000_0001, 32'h0000_00F0, 32'h001F_0002);
    cyc(1, 1, 32'h8000_0001, 32'h0000_00F0, 32'h0004_0003);
    cyc(1, 1, 32'h8000_0001, 32'h0000_00F0, 32'hFFE0_0003);
    // R12: idle cycles with changing inputs keep the result
    cyc(0, 0, 32'h1111_1111, 32'h2222_2222, 32'h0000_0000);
    cyc(0, 1, 32'h3333_3333, 32'h4444_4444, 32'h0000_0001);
    // R6: add, low and high products
    cyc(1, 0, 32'hFFFF_FFFF, 32'h0000_0002, 32'd0);
    cyc(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1);
    cyc(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd2);
    cyc(1, 0, 32'h0001_0000, 32'h0001_0000, 32'd13);
    // R7: unsigned minimum, including equal and top-bit operands
    cyc(1, 0, 32'h8000_0000, 32'h7FFF_FFFF, 32'd3);
    cyc(1, 0, 32'h0000_0042, 32'h0000_0042, 32'd14);
    // R8: rotate by b mod 32, including 0, 31, 32, 33
    cyc(1, 0, 32'h1234_5678, 32'd0, 32'd4);
    cyc(1, 0, 32'h1234_5678, 32'd31, 32'd4);
    cyc(1, 0, 32'h1234_5678, 32'd32, 32'd5);
    cyc(1, 0, 32'h1234_5678, 32'd33, 32'd5);
    // R9: bitwise
    cyc(1, 0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'd6);
    cyc(1, 0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'd7);
    cyc(1, 0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'd8);
    // R10: leading-zero sums, zero counts 32
    cyc(1, 0, 32'h0, 32'h0, 32'd9);
    cyc(1, 0, 32'h8000_0000, 32'h0000_0001, 32'd20);
    // R11: population sums
    cyc(1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd10);
    cyc(1, 0, 32'h0, 32'h0000_0101, 32'd21);
    // R2: back-to-back and isolated requests
    cyc(1, 0, 32'd5, 32'd6, 32'd0);
    cyc(0, 0, 32'd0, 32'd0, 32'd0);
    cyc(1, 1, 32'd5, 32'd6, 32'd0);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ra, rb, rs;
      bit rv, rm;
      ra = $urandom;
      rb = $urandom;
      rs = $urandom;
      if (n % 7 == 0) rb = rb % 40;
      if (n % 11 == 0) ra = ra >> (n % 32);
      rv = ($urandom % 4) != 0;
      rm = $urandom % 2;
      cyc(rv, rm, ra, rb, rs);
    end
    cyc(0, 0, 32'd0, 32'd0, 32'd0);
    @(negedge clk);
    compare_now();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule